// File: doc/BRIEF.md
# Three-State Strap Pin Detector

This block works out whether an external strap pin is tied high, tied low, or left unconnected. It never drives the pin. Instead it works the pin's internal pull resistors and reads back the synchronised pin level. A probe runs in two phases. First the pull-up is enabled and the block waits a settle interval before it samples the pin. Then the pull-down is enabled, the block waits the same interval and samples again.

When the two samples agree, the level is held by something outside the chip. When they differ, the pin follows the internal pull, so it is floating. At the end of the probe the pull is left in a state that matches the result. A pin tied high gets the pull-up. Every other result keeps the pull-down.

The settle interval is given in clock cycles on an input. A zero on that input selects a built-in default of five microseconds, computed from a cycles-per-microsecond parameter. Shorter waits are known to give unreliable readings.

Top module: `strap_probe`

## Requirements
- R1: After reset both pull enables are low, busy is low, done is low and result is 2'b00.
- R2: A start pulse seen while idle makes busy high from the next cycle. From that cycle on, only the pull-up is enabled, for exactly N cycles, where N is the effective settle count.
- R3: After the N pull-up cycles the block samples the pin. It then enables only the pull-down for another N cycles, and samples the pin again at the end of them.
- R4: The result encoding is 2'b01 when both samples are high, 2'b00 when both are low, and 2'b10 when the samples differ (floating).
- R5: When the probe completes with result 2'b01, the pull-up is left enabled. For any other result the pull-down is left enabled. The chosen pull stays in place while the block is idle.
- R6: The pull-up and pull-down enables are never high in the same cycle.
- R7: The done signal is a one-cycle pulse. It rises 2N cycles after the clock edge that accepts start, and busy falls in that same cycle. The result stays stable from then until the next probe completes.
- R8: A start pulse while busy is ignored. The phase timing, the final result and the final pull are the same as without it.
- R9: A settle input of zero selects a default of 5 × CYCLES_PER_US cycles. Any nonzero value is used directly, down to a minimum of 1.
- R10: A pin that reads low under the pull-up but high under the pull-down is classified as floating (2'b10).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse for one probe |
| pinLevel | input | 1 | Synchronised level of the strap pin |
| settleCycles | input | CNT_W | Settle interval in cycles; 0 selects the default |
| pullUpEn | output | 1 | Internal pull-up enable |
| pullDnEn | output | 1 | Internal pull-down enable |
| busy | output | 1 | Probe in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 00 low, 01 high, 10 floating |

## Verification
A wrong internal state shows up directly on the pull enables. A wrong phase state or a wrong reload of the settle counter moves the pull-up to pull-down switch away from cycle N. That mismatch is visible one cycle after the faulty edge. A broken sample register or a broken classifier only shows when done rises, at cycle 2N, through the wrong result code and the wrong pull being left on. The bench therefore checks the pulls at every phase boundary as well as at completion. It drives four pin behaviours, the minimum settle count and the default settle count.

// File: rtl/strap_probe_pkg.sv
package strap_probe_pkg;

  typedef enum logic [1:0] {
    RES_ZERO  = 2'b00,
    RES_ONE   = 2'b01,
    RES_FLOAT = 2'b10
  } strapResultT;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_UP   = 2'd1,
    S_DN   = 2'd2
  } probeStateT;

  // strobes from control to datapath
  typedef struct packed {
    logic go;     // accepted start: load counter, enable pull-up
    logic endUp;  // last pull-up cycle: take high sample, switch to pull-down
    logic endDn;  // last pull-down cycle: classify, set final pull
  } ctrlStrobesT;

  function automatic strapResultT classify(input logic hiSample, input logic loSample);
    if (hiSample && loSample)        return RES_ONE;
    else if (!hiSample && !loSample) return RES_ZERO;
    else                             return RES_FLOAT;
  endfunction

endpackage

// File: rtl/strap_probe_ctrl.sv
module strap_probe_ctrl
  import strap_probe_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        cntLast,
  output ctrlStrobesT strb,
  output logic        busy,
  output logic        done
);

  probeStateT stateQ, stateD;
  logic       doneQ;

  always_comb begin
    strb.go    = (stateQ == S_IDLE) && start;
    strb.endUp = (stateQ == S_UP) && cntLast;
    strb.endDn = (stateQ == S_DN) && cntLast;
  end

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      S_IDLE: if (start)   stateD = S_UP;
      S_UP:   if (cntLast) stateD = S_DN;
      S_DN:   if (cntLast) stateD = S_IDLE;
      default:             stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      doneQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= strb.endDn;
    end
  end

  assign busy = (stateQ != S_IDLE);
  assign done = doneQ;

  // R7: done lasts one cycle only
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ);

  // R7: busy is already low when done is seen
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> (stateQ == S_IDLE));

  // R8: a running phase holds until its counter expires, whatever start does
  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ != S_IDLE && !cntLast) |=> (stateQ == $past(stateQ)));

endmodule

// File: rtl/strap_probe_dp.sv
module strap_probe_dp
  import strap_probe_pkg::*;
#(
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned DEF_SETTLE = 625
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strb,
  input  logic             pinLevel,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             cntLast,
  output logic             pullUpEn,
  output logic             pullDnEn,
  output logic [1:0]       result
);

  localparam logic [CNT_W-1:0] DEF_N = CNT_W'(DEF_SETTLE);

  logic [CNT_W-1:0] effN;
  logic [CNT_W-1:0] cntQ;
  logic             hiSampleQ;
  logic             pullUpQ, pullDnQ;
  strapResultT      resultQ, resultD;

  assign effN    = (settleCycles == '0) ? DEF_N : settleCycles;
  assign cntLast = (cntQ == CNT_W'(1));
  assign resultD = classify(hiSampleQ, pinLevel);

  // settle counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        cntQ <= '0;
    else if (strb.go || strb.endUp)   cntQ <= effN;
    else if (cntQ != '0)              cntQ <= cntQ - CNT_W'(1);
  end

  // samples and result
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiSampleQ <= 1'b0;
      resultQ   <= RES_ZERO;
    end else begin
      if (strb.endUp) hiSampleQ <= pinLevel;
      if (strb.endDn) resultQ   <= resultD;
    end
  end

  // pull enables, each its own register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pullUpQ <= 1'b0;
      pullDnQ <= 1'b0;
    end else if (strb.go) begin
      pullUpQ <= 1'b1;
      pullDnQ <= 1'b0;
    end else if (strb.endUp) begin
      pullUpQ <= 1'b0;
      pullDnQ <= 1'b1;
    end else if (strb.endDn) begin
      pullUpQ <= (resultD == RES_ONE);
      pullDnQ <= (resultD != RES_ONE);
    end
  end

  assign pullUpEn = pullUpQ;
  assign pullDnEn = pullDnQ;
  assign result   = resultQ;

  // R6: pulls mutually exclusive
  assert_pull_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(pullUpQ && pullDnQ));

  // R2: an accepted start enables only the pull-up
  assert_up_phase_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.go |=> (pullUpQ && !pullDnQ));

  // R3: the pull-down phase reloads the full settle count
  assert_dn_reload_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.endUp |=> (pullDnQ && cntQ == $past(effN)));

  // R5: final pull agrees with the stored result
  assert_final_pull_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.endDn |=> (pullUpQ == (resultQ == RES_ONE)) && (pullDnQ != pullUpQ));

endmodule

// File: rtl/strap_probe.sv
module strap_probe
  import strap_probe_pkg::*;
#(
  parameter int unsigned CYCLES_PER_US = 125,
  parameter int unsigned SETTLE_US     = 5,
  parameter int unsigned CNT_W         = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             pinLevel,
  input  logic [CNT_W-1:0] settleCycles,
  output logic             pullUpEn,
  output logic             pullDnEn,
  output logic             busy,
  output logic             done,
  output logic [1:0]       result
);

  localparam int unsigned DEF_SETTLE = CYCLES_PER_US * SETTLE_US;

  ctrlStrobesT strb;
  logic        cntLast;

  strap_probe_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .cntLast (cntLast),
    .strb    (strb),
    .busy    (busy),
    .done    (done)
  );

  strap_probe_dp #(
    .CNT_W      (CNT_W),
    .DEF_SETTLE (DEF_SETTLE)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .pinLevel     (pinLevel),
    .settleCycles (settleCycles),
    .cntLast      (cntLast),
    .pullUpEn     (pullUpEn),
    .pullDnEn     (pullDnEn),
    .result       (result)
  );

endmodule

// File: tb/tb_strap_probe.sv
module tb_strap_probe;

  localparam int CNT_W = 16;
  localparam int DEF_N = 125 * 5;

  // pin behaviours
  localparam logic [1:0] M_LOW = 2'd0, M_HIGH = 2'd1, M_FLOAT = 2'd2, M_INV = 2'd3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [CNT_W-1:0] settleCycles = '0;
  logic [1:0]       pinMode = M_LOW;
  logic             pinLevel;
  logic             pullUpEn, pullDnEn, busy, done;
  logic [1:0]       result;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  always_comb begin
    case (pinMode)
      M_LOW:   pinLevel = 1'b0;
      M_HIGH:  pinLevel = 1'b1;
      M_FLOAT: pinLevel = pullUpEn;
      default: pinLevel = pullDnEn;
    endcase
  end

  strap_probe dut (
    .clk(clk), .rstN(rstN), .start(start), .pinLevel(pinLevel),
    .settleCycles(settleCycles), .pullUpEn(pullUpEn), .pullDnEn(pullDnEn),
    .busy(busy), .done(done), .result(result)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R6 watched on every cycle
  always @(negedge clk) begin
    if (rstN && pullUpEn && pullDnEn) begin
      testsFailed++;
      $display("FAIL R6 both pulls on: actual 1 expected 0");
    end
  end

  task automatic testReset();
    check("R1", "pullUp", pullUpEn, 0);
    check("R1", "pullDn", pullDnEn, 0);
    check("R1", "busy", busy, 0);
    check("R1", "done", done, 0);
    check("R1", "result", result, 0);
  endtask

  // one probe; n is the effective settle count, setIn the settle input
  task automatic runProbe(input string req, input logic [1:0] mode, input int n,
                          input int setIn, input bit pokeBusy, input int expRes);
    pinMode = mode;
    settleCycles = CNT_W'(setIn);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;      // after accept edge E0
    check("R2", "busy after start", busy, 1);
    check("R2", "pullUp in phase 1", pullUpEn, 1);
    check("R2", "pullDn in phase 1", pullDnEn, 0);
    if (n > 1) begin
      repeat (n - 1) @(negedge clk);   // after E0+N-1
      check("R2", "pullUp last phase-1 cycle", pullUpEn, 1);
      @(negedge clk);
    end else @(negedge clk);           // after E0+N
    check("R3", "pullDn in phase 2", pullDnEn, 1);
    check("R3", "pullUp in phase 2", pullUpEn, 0);
    if (pokeBusy) begin
      start = 1'b1; @(negedge clk); start = 1'b0;
      check("R8", "pullDn kept after busy start", pullDnEn, 1);
      if (n > 2) repeat (n - 2) @(negedge clk);
    end else if (n > 1) repeat (n - 1) @(negedge clk);
    check("R7", "done before 2N", done, 0);
    @(negedge clk);                    // after E0+2N
    check("R7", "done at 2N", done, 1);
    check("R7", "busy at done", busy, 0);
    check(req, "result", result, expRes);
    check("R5", "final pullUp", pullUpEn, (expRes == 1) ? 1 : 0);
    check("R5", "final pullDn", pullDnEn, (expRes == 1) ? 0 : 1);
    @(negedge clk);
    check("R7", "done one cycle", done, 0);
    check("R7", "result held", result, expRes);
    repeat (3) @(negedge clk);
    check("R5", "pull held idle", pullUpEn, (expRes == 1) ? 1 : 0);
  endtask

  task automatic testHigh();     runProbe("R4", M_HIGH, 4, 4, 0, 1); endtask
  task automatic testLow();      runProbe("R4", M_LOW, 4, 4, 0, 0); endtask
  task automatic testFloat();    runProbe("R4", M_FLOAT, 6, 6, 0, 2); endtask
  task automatic testInverted(); runProbe("R10", M_INV, 3, 3, 0, 2); endtask
  task automatic testBusyStart(); runProbe("R8", M_HIGH, 8, 8, 1, 1); endtask
  task automatic testMinSettle(); runProbe("R9", M_LOW, 1, 1, 0, 0); endtask
  task automatic testDefault();  runProbe("R9", M_HIGH, DEF_N, 0, 0, 1); endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testHigh();
    testLow();
    testFloat();
    testInverted();
    testBusyStart();
    testMinSettle();
    testDefault();
    testFloat();
    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (100000) @(posedge clk);
        testsRun++; testsFailed++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule